// File: doc/BRIEF.md
# Shift FIFO with Entry Invalidation

This block is a first-in first-out queue built as a shift register. A producer writes through a ready/valid enqueue port and a consumer reads through a ready/valid dequeue port. Every slot moves toward the head as the entries in front of it leave, so stored entries always sit packed from slot 0 upward. The head word is always in slot 0.

A separate invalidate port carries a strobe and a mask with one bit per slot. It marks chosen stored entries as dead in a single cycle. A dead entry is never offered to the consumer. When it reaches the head it is dropped one per cycle without any consumer handshake. When it is the youngest stored entry, the next enqueued word takes over its slot. The block suits a requester that queues work speculatively and later learns that some of the queued items are no longer needed.

Top module: `inval_shift_fifo`

## Requirements
- R1: After a synchronous reset the queue is empty: `deq_valid` is 0 and `enq_ready` is 1.
- R2: With no invalidation, words leave in the order they were accepted, also when enqueues are interleaved between dequeues.
- R3: An enqueue and a dequeue in the same cycle both complete, also when every slot is occupied. With DEPTH of 1 and the single slot full, `enq_ready` is 1 while `deq_ready` is 1.
- R4: Dequeues in consecutive cycles return consecutive entries with no idle cycle between them. `deq_valid` falls in the cycle after the last entry leaves.
- R5: While `inv_valid` is 1, mask bit 0 marks the head entry and bit i marks the entry i places behind the head. The mark is taken in that one cycle and stays after the strobe falls.
- R6: A dead entry is never presented: `deq_valid` is 1 only when slot 0 holds a live entry.
- R7: A dead head entry is dropped one per cycle even while `deq_ready` is 0. After the two oldest of three entries are marked, the third is at the head two cycles later.
- R8: Marking the head in the cycle it is being dequeued does not lower `deq_valid` in that cycle. The handshake completes, and the next entry is at the head in the following cycle.
- R9: An enqueue writes over a dead youngest entry instead of filling a new slot. This holds whether the entry was marked earlier or in the same cycle. With one stored entry marked while a word is enqueued, the new word is at the head in the next cycle.
- R10: Mask bits that point at empty slots have no effect.
- R11: `enq_ready` is 0 only when every slot is occupied and no entry leaves the head in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| enq_valid | input | 1 | Producer offers a word |
| enq_ready | output | 1 | Queue accepts a word this cycle |
| enq_data | input | WIDTH | Word to enqueue |
| deq_valid | output | 1 | Head slot holds a live word |
| deq_ready | input | 1 | Consumer takes the head word |
| deq_data | output | WIDTH | Head word |
| inv_valid | input | 1 | Invalidate strobe |
| inv_mask | input | DEPTH | Slots to mark dead, bit 0 = head |

## Verification
A plain fill-and-drain run with no invalidation, with enqueues slipped in between dequeues, separates a correct in-order queue from one that reorders words or leaves holes. A full queue offered a word with the consumer stalled, and then with the consumer ready, tells a correct ready rule apart from one that either blocks a simultaneous transfer or overfills. Invalidate patterns cover a pair of oldest entries, the head while it is being taken, the youngest entry both in the same cycle as an enqueue and in an earlier cycle, and mask bits on empty slots. Each pattern shows whether the mark lands on the right position and whether the dead entry is drained or reused. A depth-one instance and a reset during a run cover the edges of the size range and the state after reset.

// File: rtl/isf_pkg.sv
package isf_pkg;

  // Occupancy and liveness of one queue slot.
  typedef struct packed {
    logic occ;
    logic live;
  } isf_flags_t;

  // A slot accepts the incoming word when it is the first empty slot behind
  // a live neighbour, or when it holds a dead entry with nothing behind it.
  function automatic logic slot_takes(input logic s_occ, input logic s_live,
                                      input logic prv_occ, input logic prv_live,
                                      input logic nxt_occ);
    return (!s_occ && prv_occ && prv_live) || (s_occ && !s_live && !nxt_occ);
  endfunction

endpackage

// File: rtl/isf_head_ctrl.sv
module isf_head_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic head_occ,
  input  logic head_live,
  input  logic tail_occ,
  input  logic deq_ready,
  output logic head_go,
  output logic enq_ready
);

  // The head leaves when it is dead, or when it is live and the consumer takes it.
  assign head_go   = head_occ && (!head_live || deq_ready);
  assign enq_ready = !tail_occ || head_go;

  // R3
  simul_xfer_chk: assert property (@(posedge clk) disable iff (rst)
    (tail_occ && head_occ && head_live && deq_ready) |-> enq_ready);

endmodule

// File: rtl/isf_slot.sv
module isf_slot #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             kill_own,
  input  logic             nxt_occ,
  input  logic             nxt_live,
  input  logic             nxt_kill,
  input  logic [WIDTH-1:0] nxt_data,
  input  logic             prv_s_occ,
  input  logic             prv_s_live,
  input  logic             nxt_s_occ,
  output logic             occ_o,
  output logic             live_o,
  output logic [WIDTH-1:0] data_o,
  output logic             s_occ_o,
  output logic             s_live_o
);
  import isf_pkg::*;

  isf_flags_t       flags_q;
  logic [WIDTH-1:0] data_q;
  logic [WIDTH-1:0] s_data;
  logic             take;

  // Contents after this cycle's shift and invalidation, before any write.
  assign s_occ_o  = shift ? nxt_occ : flags_q.occ;
  assign s_live_o = shift ? (nxt_live && !nxt_kill) : (flags_q.live && !kill_own);
  assign s_data   = shift ? nxt_data : data_q;

  assign take = wr_en && slot_takes(s_occ_o, s_live_o, prv_s_occ, prv_s_live, nxt_s_occ);

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
    end else begin
      flags_q.occ  <= s_occ_o || take;
      flags_q.live <= (s_occ_o && s_live_o) || take;
    end
  end

  always_ff @(posedge clk) begin
    data_q <= take ? wr_data : s_data;
  end

  assign occ_o  = flags_q.occ;
  assign live_o = flags_q.live;
  assign data_o = data_q;

  // R6
  live_needs_occ_chk: assert property (@(posedge clk) disable iff (rst)
    flags_q.live |-> flags_q.occ);

endmodule

// File: rtl/inval_shift_fifo.sv
module inval_shift_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enq_valid,
  output logic             enq_ready,
  input  logic [WIDTH-1:0] enq_data,
  output logic             deq_valid,
  input  logic             deq_ready,
  output logic [WIDTH-1:0] deq_data,
  input  logic             inv_valid,
  input  logic [DEPTH-1:0] inv_mask
);

  logic [DEPTH-1:0] occ, live, s_occ, s_live, kill;
  logic [WIDTH-1:0] data [DEPTH];
  logic             head_go, enq_fire;

  assign kill     = {DEPTH{inv_valid}} & inv_mask & occ;
  assign enq_fire = enq_valid && enq_ready;

  isf_head_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .head_occ  (occ[0]),
    .head_live (live[0]),
    .tail_occ  (occ[DEPTH-1]),
    .deq_ready (deq_ready),
    .head_go   (head_go),
    .enq_ready (enq_ready)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic             n_occ, n_live, n_kill, n_socc, p_socc, p_slive;
    logic [WIDTH-1:0] n_data;

    if (i == DEPTH - 1) begin : g_last
      assign n_occ  = 1'b0;
      assign n_live = 1'b0;
      assign n_kill = 1'b0;
      assign n_data = '0;
      assign n_socc = 1'b0;
    end else begin : g_inner
      assign n_occ  = occ[i+1];
      assign n_live = live[i+1];
      assign n_kill = kill[i+1];
      assign n_data = data[i+1];
      assign n_socc = s_occ[i+1];
    end

    if (i == 0) begin : g_head
      assign p_socc  = 1'b1;
      assign p_slive = 1'b1;
    end else begin : g_behind
      assign p_socc  = s_occ[i-1];
      assign p_slive = s_live[i-1];
    end

    isf_slot #(.WIDTH(WIDTH)) u_slot (
      .clk        (clk),
      .rst        (rst),
      .shift      (head_go),
      .wr_en      (enq_fire),
      .wr_data    (enq_data),
      .kill_own   (kill[i]),
      .nxt_occ    (n_occ),
      .nxt_live   (n_live),
      .nxt_kill   (n_kill),
      .nxt_data   (n_data),
      .prv_s_occ  (p_socc),
      .prv_s_live (p_slive),
      .nxt_s_occ  (n_socc),
      .occ_o      (occ[i]),
      .live_o     (live[i]),
      .data_o     (data[i]),
      .s_occ_o    (s_occ[i]),
      .s_live_o   (s_live[i])
    );
  end

  assign deq_valid = occ[0] && live[0];
  assign deq_data  = data[0];

  // R11
  full_block_chk: assert property (@(posedge clk) disable iff (rst)
    !enq_ready |-> (&occ));

  // R7
  dead_head_drain_chk: assert property (@(posedge clk) disable iff (rst)
    (occ[0] && !live[0] && !enq_fire) |=> ($countones(occ) == $past($countones(occ)) - 1));

  for (genvar j = 0; j + 1 < DEPTH; j++) begin : g_pack
    // R2
    packed_chk: assert property (@(posedge clk) disable iff (rst)
      occ[j+1] |-> occ[j]);
  end

  if (DEPTH > 1) begin : g_bubble
    // R4
    no_bubble_chk: assert property (@(posedge clk) disable iff (rst)
      (deq_valid && deq_ready && live[1] && !(inv_valid && inv_mask[1])) |=> deq_valid);
  end

endmodule

// File: tb/inval_shift_fifo_test.sv
module inval_shift_fifo_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam int WIDTH = 8;
  localparam int NV = 26;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic             rst, enq_valid, deq_ready, inv_valid;
  logic [WIDTH-1:0] enq_data;
  logic [DEPTH-1:0] inv_mask;
  logic             enq_ready, deq_valid;
  logic [WIDTH-1:0] deq_data;

  logic             e1_valid, d1_ready, i1_valid;
  logic [WIDTH-1:0] e1_data;
  logic [0:0]       i1_mask;
  logic             e1_ready, d1_valid;
  logic [WIDTH-1:0] d1_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  inval_shift_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) uut (
    .clk(clk), .rst(rst), .enq_valid(enq_valid), .enq_ready(enq_ready),
    .enq_data(enq_data), .deq_valid(deq_valid), .deq_ready(deq_ready),
    .deq_data(deq_data), .inv_valid(inv_valid), .inv_mask(inv_mask));

  inval_shift_fifo #(.DEPTH(1), .WIDTH(WIDTH)) uut_d1 (
    .clk(clk), .rst(rst), .enq_valid(e1_valid), .enq_ready(e1_ready),
    .enq_data(e1_data), .deq_valid(d1_valid), .deq_ready(d1_ready),
    .deq_data(d1_data), .inv_valid(i1_valid), .inv_mask(i1_mask));

  // Row: {req, enq_valid, enq_data, deq_ready, inv_valid, inv_mask, exp_valid, exp_data, exp_ready}
  function automatic logic [28:0] mk(input logic [3:0] rq, input logic ev, input logic [7:0] ed,
                                     input logic dr, input logic iv, input logic [3:0] im,
                                     input logic xv, input logic [7:0] xd, input logic xr);
    return {rq, ev, ed, dr, iv, im, xv, xd, xr};
  endfunction

  localparam logic [28:0] VEC [NV] = '{
    mk(2, 1, 8'h12, 0, 0, 4'h0, 0, 8'h00, 1),  // R2 first word into empty queue
    mk(2, 1, 8'h34, 0, 0, 4'h0, 1, 8'h12, 1),
    mk(2, 1, 8'h56, 0, 0, 4'h0, 1, 8'h12, 1),
    mk(2, 0, 8'h00, 1, 0, 4'h0, 1, 8'h12, 1),
    mk(4, 0, 8'h00, 1, 0, 4'h0, 1, 8'h34, 1),  // R4 back to back
    mk(2, 1, 8'h78, 0, 0, 4'h0, 1, 8'h56, 1),  // R2 enqueue between dequeues
    mk(2, 0, 8'h00, 1, 0, 4'h0, 1, 8'h56, 1),
    mk(3, 1, 8'h9A, 1, 0, 4'h0, 1, 8'h78, 1),  // R3 simultaneous
    mk(3, 0, 8'h00, 1, 0, 4'h0, 1, 8'h9A, 1),
    mk(4, 0, 8'h00, 1, 0, 4'h0, 0, 8'h00, 1),  // R4 empty after last
    mk(2, 1, 8'hA1, 0, 0, 4'h0, 0, 8'h00, 1),
    mk(2, 1, 8'hA2, 0, 0, 4'h0, 1, 8'hA1, 1),
    mk(2, 1, 8'hA3, 0, 0, 4'h0, 1, 8'hA1, 1),
    mk(2, 1, 8'hA4, 0, 0, 4'h0, 1, 8'hA1, 1),
    mk(11, 1, 8'hB1, 0, 0, 4'h0, 1, 8'hA1, 0), // R11 full, consumer stalled
    mk(3, 1, 8'hB1, 1, 0, 4'h0, 1, 8'hA1, 1),  // R3 full queue, enq and deq
    mk(5, 0, 8'h00, 0, 1, 4'h3, 1, 8'hA2, 0),  // R5 mark two oldest
    mk(6, 0, 8'h00, 0, 0, 4'h0, 0, 8'h00, 1),  // R6 dead head hidden, drains
    mk(7, 0, 8'h00, 0, 0, 4'h0, 0, 8'h00, 1),  // R7 second dead head drains
    mk(7, 0, 8'h00, 0, 0, 4'h0, 1, 8'hA4, 1),  // R7 third entry two cycles later
    mk(8, 0, 8'h00, 1, 1, 4'h1, 1, 8'hA4, 1),  // R8 mark head while taken
    mk(8, 1, 8'hC1, 0, 1, 4'h1, 1, 8'hB1, 1),  // R8/R9 next at head; tail reuse
    mk(10, 1, 8'hC2, 0, 1, 4'hE, 1, 8'hC1, 1), // R9 new word at head; R10 empty bits
    mk(10, 0, 8'h00, 1, 0, 4'h0, 1, 8'hC1, 1),
    mk(10, 0, 8'h00, 1, 0, 4'h0, 1, 8'hC2, 1), // R10 C2 survived
    mk(4, 0, 8'h00, 1, 0, 4'h0, 0, 8'h00, 1)
  };

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    enq_valid = 0; enq_data = '0; deq_ready = 0; inv_valid = 0; inv_mask = '0;
    e1_valid = 0; e1_data = '0; d1_ready = 0; i1_valid = 0; i1_mask = '0;
  endtask

  task automatic drive(input logic ev, input logic [7:0] ed, input logic dr,
                       input logic iv, input logic [3:0] im);
    enq_valid = ev; enq_data = ed; deq_ready = dr; inv_valid = iv; inv_mask = im;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    // R1 reset state
    check("R1", "deq_valid after reset", deq_valid, 0);
    check("R1", "enq_ready after reset", enq_ready, 1);

    for (int k = 0; k < NV; k++) begin
      logic [28:0] v;
      string rq;
      v = VEC[k];
      @(negedge clk);
      drive(v[24], v[23:16], v[15], v[14], v[13:10]);
      #1;
      rq = $sformatf("R%0d", v[28:25]);
      check(rq, $sformatf("row %0d enq_ready", k), enq_ready, v[0]);
      check(rq, $sformatf("row %0d deq_valid", k), deq_valid, v[9]);
      if (v[9]) check(rq, $sformatf("row %0d deq_data", k), deq_data, v[8:1]);
    end

    // R9 dead youngest entry marked in an earlier cycle is reused
    @(negedge clk); drive(1, 8'hD1, 0, 0, 4'h0);
    @(negedge clk); drive(1, 8'hD2, 0, 0, 4'h0);
    @(negedge clk); drive(0, 8'h00, 0, 1, 4'h2);
    @(negedge clk); drive(1, 8'hD3, 0, 0, 4'h0);
    @(negedge clk); drive(0, 8'h00, 1, 0, 4'h0);
    #1;
    check("R9", "head before reuse drain", deq_data, 8'hD1);
    @(negedge clk); #1;
    check("R9", "reused slot valid", deq_valid, 1);
    check("R9", "reused slot data", deq_data, 8'hD3);
    @(negedge clk); #1;
    check("R9", "empty after reuse drain", deq_valid, 0);

    // R3 depth-one queue
    @(negedge clk); drive(0, 8'h00, 0, 0, 4'h0);
    e1_valid = 1; e1_data = 8'h12; d1_ready = 0;
    @(negedge clk);
    e1_valid = 1; e1_data = 8'h34; d1_ready = 0; #1;
    check("R11", "depth1 full stalled enq_ready", e1_ready, 0);
    d1_ready = 1; #1;
    check("R3", "depth1 full enq_ready with deq_ready", e1_ready, 1);
    check("R3", "depth1 head", d1_data, 8'h12);
    @(negedge clk);
    e1_valid = 1; e1_data = 8'h56; d1_ready = 1; #1;
    check("R3", "depth1 second word", d1_data, 8'h34);
    check("R3", "depth1 second enq_ready", e1_ready, 1);
    @(negedge clk);
    e1_valid = 0; d1_ready = 1; #1;
    check("R4", "depth1 third word valid", d1_valid, 1);
    check("R4", "depth1 third word", d1_data, 8'h56);
    @(negedge clk); #1;
    check("R4", "depth1 empty", d1_valid, 0);

    // R1 reset during a run
    @(negedge clk); idle_inputs(); drive(1, 8'hE1, 0, 0, 4'h0);
    @(negedge clk); drive(1, 8'hE2, 0, 0, 4'h0);
    @(negedge clk); idle_inputs(); rst = 1;
    @(negedge clk); rst = 0; #1;
    check("R1", "deq_valid after mid-run reset", deq_valid, 0);
    check("R1", "enq_ready after mid-run reset", enq_ready, 1);

    done = 1;
    summary();
    $finish;
  end

endmodule